// File: doc/BRIEF.md
# Tagged Register File with Result-Bus Snoop

This block is the architectural register store of a dynamically scheduled core. Each of its registers holds a data word and a producer tag. The tag names the in-flight operation that will supply the register's next value. A tag of zero means the data word is current. Issue logic marks a destination register as pending by writing a new producer tag into it. The register file never accepts data by address. It watches the result bus instead, and every register whose stored tag equals the broadcast tag loads the broadcast value and marks itself current.

Two independent read ports return the data and the tag for their addresses combinationally. A consumer therefore learns in one lookup whether an operand is ready or which producer to wait for. A result on the bus in the same cycle is forwarded to a read port whose register is waiting on that result. The consumer then sees the value with a zero tag and does not miss the broadcast.

Top module: `tagged_regfile`

## Requirements
- R1: A synchronous active-low reset clears every data word and every tag to zero. After reset, both read ports return data 0 and tag 0 for every address.
- R2: When `iss_en` is high at a rising edge, the register at `iss_addr` stores `iss_tag` as its tag. Its data word does not change. Read ports show the new tag from the next cycle.
- R3: When `bus_vld` is high and `bus_tag` is nonzero at a rising edge, each register whose stored tag equals `bus_tag` loads `bus_val` and clears its tag to zero.
- R4: All registers that hold the same matching tag capture the same bus value in the same cycle.
- R5: A bus tag of zero never matches any register, even when `bus_vld` is high. Registers with tag zero keep their data.
- R6: While `bus_vld` is low, no register captures the bus value, whatever `bus_tag` is.
- R7: If issue writes a register in the cycle that the bus matches that register's old tag, the register takes the bus value and keeps the newly issued tag.
- R8: Reads are combinational. When the addressed register's stored tag matches a valid nonzero bus tag, the port returns `bus_val` with tag zero in that same cycle. An issue write in the same cycle does not affect that cycle's read.
- R9: The two read ports are independent, and both may address the same register at once.
- R10: A register that is neither issued nor matched keeps its data and its tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd0_addr | input | 5 | Read port 0 register address |
| rd0_data | output | 32 | Read port 0 data (forwarded when pending on the live bus) |
| rd0_tag | output | 5 | Read port 0 producer tag, zero when the data is current |
| rd1_addr | input | 5 | Read port 1 register address |
| rd1_data | output | 32 | Read port 1 data |
| rd1_tag | output | 5 | Read port 1 producer tag |
| iss_en | input | 1 | Issue writes a producer tag this cycle |
| iss_addr | input | 5 | Destination register of the issue write |
| iss_tag | input | 5 | Producer tag to store |
| bus_vld | input | 1 | Result bus carries a result this cycle |
| bus_tag | input | 5 | Tag of the producing operation (zero never matches) |
| bus_val | input | 32 | Result value |

## Verification
Read-port results, including forwarding from the live bus, are due in the same cycle as their inputs. Tag writes and bus captures become visible one rising edge after they are applied. The bench drives every input just after a falling edge and compares both ports 1 ns later, before the next rising edge. At that point it uses a behavioural model that still holds the pre-edge state. The model takes the issue and bus effects only after that comparison, so each stored effect is checked in the following cycle. A same-cycle issue write is checked as invisible in the cycle it is applied.

// File: rtl/rf_pkg.sv
// Package rf_pkg
// Shared sizing defaults for the tagged register file.
// Assumes the register count is a power of two so that every address decodes to a slot.
package rf_pkg;
    localparam int RF_NREG = 32;  // number of architectural registers
    localparam int RF_DW   = 32;  // data word width
    localparam int RF_TW   = 5;   // producer tag width; value zero means "current"
    localparam int RF_NRD  = 2;   // number of read ports
endpackage

// File: rtl/rf_slot.sv
// Module rf_slot
// One register of the file: a data word and a producer tag.
// It snoops the result bus and captures a value whose tag equals its own stored tag.
// Assumes the caller has already decoded the issue address into iss_hit.
// A bus tag of zero is never a match.
module rf_slot #(
    parameter int DW = 32,
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_hit,
    input  logic [TW-1:0] iss_tag,
    input  logic          bus_vld,
    input  logic [TW-1:0] bus_tag,
    input  logic [DW-1:0] bus_val,
    output logic [DW-1:0] data_q,
    output logic [TW-1:0] tag_q
);
    logic          snoop_hit;
    logic [DW-1:0] data_d;
    logic [TW-1:0] tag_d;

    // Purpose: detect that the live broadcast carries the result this slot waits for.
    always_comb begin
        snoop_hit = bus_vld && (bus_tag != '0) && (tag_q == bus_tag);
    end

    // Purpose: next state; a bus capture clears the tag, and an issue write overrides that.
    always_comb begin
        data_d = data_q;
        tag_d  = tag_q;
        if (snoop_hit) begin
            data_d = bus_val;
            tag_d  = '0;
        end
        if (iss_hit) begin
            tag_d = iss_tag;
        end
    end

    // Purpose: state register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            tag_q  <= '0;
        end else begin
            data_q <= data_d;
            tag_q  <= tag_d;
        end
    end

    assert_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (data_q == '0 && tag_q == '0));

    assert_issue_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_hit |=> tag_q == $past(iss_tag));

    assert_issue_keeps_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_hit && !snoop_hit) |=> $stable(data_q));

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_hit && !iss_hit) |=> (data_q == $past(bus_val) && tag_q == '0));

    assert_zero_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_tag == '0 && !iss_hit) |=> ($stable(data_q) && $stable(tag_q)));

    assert_race_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_hit && iss_hit) |=> (data_q == $past(bus_val) && tag_q == $past(iss_tag)));

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_vld && !iss_hit) |=> ($stable(data_q) && $stable(tag_q)));
endmodule

// File: rtl/rf_rdport.sv
// Module rf_rdport
// One combinational read port: it selects a slot by address and forwards a live bus result
// that the selected slot is waiting for, reporting tag zero in that case.
// Assumes addr is below NREG.
module rf_rdport #(
    parameter int NREG = 32,
    parameter int DW   = 32,
    parameter int TW   = 5,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREG-1:0][DW-1:0]  data_all,
    input  logic [NREG-1:0][TW-1:0]  tag_all,
    input  logic [AW-1:0]            addr,
    input  logic                     bus_vld,
    input  logic [TW-1:0]            bus_tag,
    input  logic [DW-1:0]            bus_val,
    output logic [DW-1:0]            rd_data,
    output logic [TW-1:0]            rd_tag
);
    logic [DW-1:0] sel_data;
    logic [TW-1:0] sel_tag;
    logic          fwd;

    // Purpose: pick the addressed slot's stored contents.
    always_comb begin
        sel_data = data_all[addr];
        sel_tag  = tag_all[addr];
    end

    // Purpose: forward the bus value when the addressed slot is pending on it.
    always_comb begin
        fwd = bus_vld && (bus_tag != '0) && (sel_tag == bus_tag);
        if (fwd) begin
            rd_data = bus_val;
            rd_tag  = '0;
        end else begin
            rd_data = sel_data;
            rd_tag  = sel_tag;
        end
    end

    // A port never reports a producer tag that is being broadcast right now.
    assert_fwd_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && bus_tag != '0) |-> (rd_tag != bus_tag));
endmodule

// File: rtl/tagged_regfile.sv
// Module tagged_regfile
// Register file with one producer tag per register. Issue writes tags by address,
// and data arrives only by snooping the result bus. Two combinational read ports
// return data and tag, with same-cycle forwarding from the bus.
// Assumes at most one issue write per cycle and one result broadcast per cycle.
module tagged_regfile #(
    parameter int NREG = rf_pkg::RF_NREG,
    parameter int DW   = rf_pkg::RF_DW,
    parameter int TW   = rf_pkg::RF_TW,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd0_addr,
    output logic [DW-1:0] rd0_data,
    output logic [TW-1:0] rd0_tag,
    input  logic [AW-1:0] rd1_addr,
    output logic [DW-1:0] rd1_data,
    output logic [TW-1:0] rd1_tag,
    input  logic          iss_en,
    input  logic [AW-1:0] iss_addr,
    input  logic [TW-1:0] iss_tag,
    input  logic          bus_vld,
    input  logic [TW-1:0] bus_tag,
    input  logic [DW-1:0] bus_val
);
    localparam int NRD = rf_pkg::RF_NRD;

    logic [NREG-1:0]          iss_hit;
    logic [NREG-1:0][DW-1:0]  data_all;
    logic [NREG-1:0][TW-1:0]  tag_all;
    logic [NRD-1:0][AW-1:0]   rd_addr;
    logic [NRD-1:0][DW-1:0]   rd_data;
    logic [NRD-1:0][TW-1:0]   rd_tag;

    // Purpose: decode the issue destination into one-hot slot enables.
    for (genvar r = 0; r < NREG; r++) begin : g_dec
        assign iss_hit[r] = iss_en && (iss_addr == AW'(r));
    end

    // Purpose: one snooping slot per architectural register.
    for (genvar r = 0; r < NREG; r++) begin : g_slot
        rf_slot #(.DW(DW), .TW(TW)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .iss_hit (iss_hit[r]),
            .iss_tag (iss_tag),
            .bus_vld (bus_vld),
            .bus_tag (bus_tag),
            .bus_val (bus_val),
            .data_q  (data_all[r]),
            .tag_q   (tag_all[r])
        );
    end

    assign rd_addr[0] = rd0_addr;
    assign rd_addr[1] = rd1_addr;

    // Purpose: identical, independent read ports.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        rf_rdport #(.NREG(NREG), .DW(DW), .TW(TW)) u_rd (
            .clk      (clk),
            .rst_n    (rst_n),
            .data_all (data_all),
            .tag_all  (tag_all),
            .addr     (rd_addr[p]),
            .bus_vld  (bus_vld),
            .bus_tag  (bus_tag),
            .bus_val  (bus_val),
            .rd_data  (rd_data[p]),
            .rd_tag   (rd_tag[p])
        );
    end

    assign rd0_data = rd_data[0];
    assign rd0_tag  = rd_tag[0];
    assign rd1_data = rd_data[1];
    assign rd1_tag  = rd_tag[1];

    // At most one slot takes an issue write per cycle.
    assert_one_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(iss_hit));

    // Two ports on the same address agree.
    assert_ports_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_addr == rd1_addr) |-> (rd0_data == rd1_data && rd0_tag == rd1_tag));
endmodule

// File: tb/sim_tagged_regfile.sv
`timescale 1ns/1ps
module sim_tagged_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd0_addr = '0, rd1_addr = '0;
    logic [31:0] rd0_data, rd1_data;
    logic [4:0]  rd0_tag, rd1_tag;
    logic        iss_en = 1'b0;
    logic [4:0]  iss_addr = '0, iss_tag = '0;
    logic        bus_vld = 1'b0;
    logic [4:0]  bus_tag = '0;
    logic [31:0] bus_val = '0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] m_data [32];
    logic [4:0]  m_tag  [32];

    always #2 clk = ~clk;  // 250 MHz

    tagged_regfile u0 (
        .clk(clk), .rst_n(rst_n),
        .rd0_addr(rd0_addr), .rd0_data(rd0_data), .rd0_tag(rd0_tag),
        .rd1_addr(rd1_addr), .rd1_data(rd1_data), .rd1_tag(rd1_tag),
        .iss_en(iss_en), .iss_addr(iss_addr), .iss_tag(iss_tag),
        .bus_vld(bus_vld), .bus_tag(bus_tag), .bus_val(bus_val)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_data(input logic [4:0] a);
        if (bus_vld && bus_tag != 0 && m_tag[a] == bus_tag) return bus_val;
        return m_data[a];
    endfunction

    function automatic logic [4:0] exp_tag(input logic [4:0] a);
        if (bus_vld && bus_tag != 0 && m_tag[a] == bus_tag) return 5'd0;
        return m_tag[a];
    endfunction

    // One cycle: drive after the falling edge, compare, then advance the model.
    task automatic cyc(input string req, input logic ie, input logic [4:0] ia,
                       input logic [4:0] it, input logic bv, input logic [4:0] bt,
                       input logic [31:0] bval, input logic [4:0] a0, input logic [4:0] a1);
        @(negedge clk);
        iss_en = ie; iss_addr = ia; iss_tag = it;
        bus_vld = bv; bus_tag = bt; bus_val = bval;
        rd0_addr = a0; rd1_addr = a1;
        #1;
        check(req, "rd0_data", rd0_data, exp_data(a0));
        check(req, "rd0_tag", {27'd0, rd0_tag}, {27'd0, exp_tag(a0)});
        check(req, "rd1_data", rd1_data, exp_data(a1));
        check(req, "rd1_tag", {27'd0, rd1_tag}, {27'd0, exp_tag(a1)});
        for (int r = 0; r < 32; r++) begin
            if (bv && bt != 0 && m_tag[r] == bt) begin
                m_data[r] = bval;
                m_tag[r]  = 5'd0;
            end
        end
        if (ie) m_tag[ia] = it;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        iss_en = 0; bus_vld = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < 32; r++) begin
            m_data[r] = '0;
            m_tag[r]  = '0;
        end
    endtask

    initial begin
        do_reset();
        // R1: every address reads back zero after reset
        for (int a = 0; a < 32; a += 2)
            cyc("R1", 0, 0, 0, 0, 0, 0, 5'(a), 5'(a + 1));
        // R2: tag written, data untouched, visible next cycle; same-cycle read unaffected (R8)
        cyc("R8", 1, 5, 3, 0, 0, 0, 5, 5);
        cyc("R2", 0, 0, 0, 0, 0, 0, 5, 4);
        // R8: forwarded in the matching cycle; R3: stored afterwards with tag cleared
        cyc("R8", 0, 0, 0, 1, 3, 32'hDEAD_BEEF, 5, 6);
        cyc("R3", 0, 0, 0, 0, 0, 0, 5, 6);
        // R4: three registers waiting on the same producer
        cyc("R4", 1, 1, 6, 0, 0, 0, 0, 0);
        cyc("R4", 1, 2, 6, 0, 0, 0, 0, 0);
        cyc("R4", 1, 9, 6, 0, 0, 0, 1, 9);
        cyc("R4", 0, 0, 0, 1, 6, 32'h1234_5678, 1, 2);
        cyc("R4", 0, 0, 0, 0, 0, 0, 1, 2);
        cyc("R4", 0, 0, 0, 0, 0, 0, 9, 3);
        // R5: zero bus tag matches nothing
        cyc("R5", 0, 0, 0, 1, 0, 32'hBAD0_BAD0, 3, 5);
        cyc("R5", 0, 0, 0, 0, 0, 0, 3, 5);
        // R6: invalid bus does not capture
        cyc("R6", 1, 7, 4, 0, 0, 0, 7, 7);
        cyc("R6", 0, 0, 0, 0, 4, 32'hCAFE_0001, 7, 8);
        cyc("R6", 0, 0, 0, 0, 0, 0, 7, 8);
        // R7: issue and match race on register 7
        cyc("R7", 1, 7, 5, 1, 4, 32'h0BAD_F00D, 7, 7);
        cyc("R7", 0, 0, 0, 0, 0, 0, 7, 7);
        cyc("R7", 0, 0, 0, 1, 5, 32'h7777_7777, 7, 7);
        cyc("R7", 0, 0, 0, 0, 0, 0, 7, 5);
        // R9: both ports on the same and on different registers
        cyc("R9", 0, 0, 0, 0, 0, 0, 9, 9);
        cyc("R9", 0, 0, 0, 0, 0, 0, 2, 7);
        // R10: random traffic against the model
        for (int i = 0; i < 3000; i++)
            cyc("R10", 1'($urandom_range(1)), 5'($urandom_range(31)), 5'($urandom_range(7)),
                1'($urandom_range(1)), 5'($urandom_range(7)), $urandom,
                5'($urandom_range(31)), 5'($urandom_range(31)));
        // R1: reset again after random traffic
        do_reset();
        for (int a = 0; a < 32; a += 2)
            cyc("R1", 0, 0, 0, 0, 0, 0, 5'(a), 5'(a + 1));
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule